// File: doc/BRIEF.md
# Prefetch Candidate Queue

This block sits between a prefetch address generator and the memory-side bus of a cache. It holds up to `DEPTH` cache-line prefetch candidates in age order. A demand miss first passes a filter: uncacheable misses are dropped, and so are instruction-fetch misses while the data-only mode is on. An accepted miss cancels any queued entry for the same block. With serial squash enabled, it also trims younger speculative entries from the tail. Its timestamp then becomes the base time for the candidates that follow.

Candidates arrive one per cycle, each as an address and a delay. A candidate is dropped if the miss-status holding registers already track its block, if the queue already holds it, or, in check-on-push mode, if the cache already has it. Otherwise it is appended, and the oldest entry is discarded first when the queue is full. The cache and the miss-status registers are looked up through combinational query ports. The issue port presents the oldest entry. In check-at-pop mode, a head that is found in the cache is discarded instead of issued. The bus request stays high while the queue holds entries.

Top module: `pf_cand_queue`

## Requirements
- R1: After reset the queue is empty: `bus_req` and `iss_valid` are 0 and every event counter reads 0.
- R2: A miss with `miss_uncacheable`=1 has no effect, and neither does a miss with `miss_ifetch`=1 while `cfg_data_only`=1. Such a miss does not cancel entries and does not update the base time. While `cfg_data_only`=0, an instruction-fetch miss is accepted.
- R3: Every stored, compared and issued address is a block address: the input address with its low log2(`BLK_BYTES`) bits forced to 0.
- R4: When an accepted miss has the same block address as a queued entry, that entry is removed. The entries on either side of it keep their relative order. An entry that is being popped in the same cycle is issued rather than removed.
- R5: With `cfg_serial_squash`=1, an accepted miss with time T removes tail entries while the tail entry's ready time is >= T. It stops at the first entry with a smaller ready time, or when the queue is empty. With `cfg_serial_squash`=0, no entry is squashed. Within a cycle, miss removal comes first, then squash, then the candidate push.
- R6: A pushed entry's ready time is the time of the last accepted miss plus `cand_delay`, and it is presented on `iss_time`.
- R7: A candidate is dropped if `cand_mshr_hit`=1 for its block, or if its block is already queued. The queue never holds two entries with the same block.
- R8: With `cfg_check_on_push`=1, a candidate is dropped when `cand_cache_hit`=1.
- R9: A push into a full queue discards the head (oldest) entry and places the candidate at the tail. The occupancy never exceeds `DEPTH`.
- R10: `bus_req` is 1 exactly while the queue is non-empty. After each push, `bus_req_time` holds the ready time of the new entry.
- R11: With `cfg_check_on_push`=0, a head entry with `head_cache_hit`=1 is not presented (`iss_valid`=0). It is discarded on the next clock edge, one entry per cycle. If all entries go this way, nothing is issued.
- R12: Entries issue in the order they were pushed. The head pops on a clock edge where `iss_valid`=1 and `iss_ready`=1.
- R13: `stat_flat` carries eight `CNT_W`-bit counters. Counter i sits at bits [i*CNT_W +: CNT_W], and the indices are:
  - 0: candidates seen
  - 1: MSHR drops
  - 2: cache drops, at push or at pop
  - 3: queue-duplicate drops
  - 4: overflow evictions
  - 5: miss removals
  - 6: squashed entries, counting each one
  - 7: issued prefetches

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch misses |
| cfg_serial_squash | input | 1 | Enable tail squash on accepted miss |
| cfg_check_on_push | input | 1 | 1: cache check at push, 0: at pop |
| miss_valid | input | 1 | Demand miss present |
| miss_addr | input | ADDR_W | Miss byte address |
| miss_time | input | TIME_W | Miss timestamp |
| miss_uncacheable | input | 1 | Miss is to uncacheable space |
| miss_ifetch | input | 1 | Miss is an instruction fetch |
| cand_valid | input | 1 | Prefetch candidate present |
| cand_addr | input | ADDR_W | Candidate byte address |
| cand_delay | input | DELAY_W | Candidate delay from miss time |
| cand_cache_addr | output | ADDR_W | Cache lookup address for the candidate |
| cand_cache_hit | input | 1 | Candidate block is in the cache |
| cand_mshr_addr | output | ADDR_W | MSHR lookup address for the candidate |
| cand_mshr_hit | input | 1 | Candidate block is in the MSHRs |
| head_cache_addr | output | ADDR_W | Cache lookup address for the head entry |
| head_cache_hit | input | 1 | Head block is in the cache |
| iss_valid | output | 1 | A prefetch is offered |
| iss_ready | input | 1 | Bus accepts the offered prefetch |
| iss_addr | output | ADDR_W | Offered block address |
| iss_time | output | TIME_W | Offered ready time |
| bus_req | output | 1 | Memory-side bus request |
| bus_req_time | output | TIME_W | Ready time of the latest push |
| stat_flat | output | 8*CNT_W | Packed event counters |

## Verification
The bench builds the block with DEPTH=4, BLK_BYTES=64, TIME_W=16, DELAY_W=8 and CNT_W=16. A depth of four makes overflow eviction reachable with a fifth distinct push. It also lets a single miss squash almost the whole queue. Sixty-four-byte blocks let a few small addresses show offset masking and same-block deduplication. A small ready-time range keeps the squash boundary (ready time equal to the miss time) easy to place exactly.

// File: rtl/pfq_pkg.sv
// Shared constants for the prefetch candidate queue.
// Assumes: consumers index the event vector with these positions.
package pfq_pkg;
    localparam int NUM_EV    = 8;
    localparam int EV_IDENT  = 0;
    localparam int EV_MSHR   = 1;
    localparam int EV_CACHE  = 2;
    localparam int EV_QHIT   = 3;
    localparam int EV_EVICT  = 4;
    localparam int EV_REMOVE = 5;
    localparam int EV_SQUASH = 6;
    localparam int EV_ISSUE  = 7;
endpackage

// File: rtl/pfq_miss_filter.sv
// Accepts or ignores a demand miss and forms its block address.
// Assumes: BLK_BYTES is a power of two.
module pfq_miss_filter #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic              miss_valid,
    input  logic              miss_uncacheable,
    input  logic              miss_ifetch,
    input  logic              data_only,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_acc,
    output logic [ADDR_W-1:0] miss_blk
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);

    // Acceptance rule: cacheable, and not an ifetch while in data-only mode.
    assign miss_acc = miss_valid && !miss_uncacheable && !(miss_ifetch && data_only);
    // Block address: clear the offset bits.
    assign miss_blk = miss_addr & ~OFF_MASK;
endmodule

// File: rtl/pfq_cam.sv
// Fully associative block-address match across all queue slots.
// Assumes: stored addresses are already block aligned.
module pfq_cam #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic [ADDR_W-1:0] ent_addr [DEPTH],
    input  logic [DEPTH-1:0]  live,
    input  logic [ADDR_W-1:0] key,
    output logic [DEPTH-1:0]  hit
);
    // One comparator per slot, qualified by occupancy.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit[g] = live[g] && (ent_addr[g] == key);
    end
endmodule

// File: rtl/pfq_stats.sv
// Event counters, one per event class, packed into a flat vector.
// Assumes: only the squash event carries a multi-entry increment.
module pfq_stats
    import pfq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_EV-1:0]       ev,
    input  logic [CNT_W-1:0]        sq_n,
    output logic [NUM_EV*CNT_W-1:0] stat_flat
);
    for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt_r;
        logic [CNT_W-1:0] inc;
        if (g == EV_SQUASH) begin : g_multi
            assign inc = ev[g] ? sq_n : '0;
        end else begin : g_single
            assign inc = {{(CNT_W-1){1'b0}}, ev[g]};
        end
        // Accumulate this event class.
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_r <= '0;
            else        cnt_r <= cnt_r + inc;
        end
        assign stat_flat[g*CNT_W +: CNT_W] = cnt_r;
    end
endmodule

// File: rtl/pf_cand_queue.sv
// Prefetch candidate queue: an age-ordered, compacted array of block
// addresses with ready times. A miss removal, a tail squash, a head pop
// and one candidate push are all resolved in a single cycle.
// Assumes: DEPTH >= 2, BLK_BYTES is a power of two, and candidates use
// the time of the last accepted miss as their base.
module pf_cand_queue
    import pfq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int DEPTH     = 4,
    parameter int TIME_W    = 16,
    parameter int DELAY_W   = 8,
    parameter int CNT_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_data_only,
    input  logic                    cfg_serial_squash,
    input  logic                    cfg_check_on_push,
    input  logic                    miss_valid,
    input  logic [ADDR_W-1:0]       miss_addr,
    input  logic [TIME_W-1:0]       miss_time,
    input  logic                    miss_uncacheable,
    input  logic                    miss_ifetch,
    input  logic                    cand_valid,
    input  logic [ADDR_W-1:0]       cand_addr,
    input  logic [DELAY_W-1:0]      cand_delay,
    output logic [ADDR_W-1:0]       cand_cache_addr,
    input  logic                    cand_cache_hit,
    output logic [ADDR_W-1:0]       cand_mshr_addr,
    input  logic                    cand_mshr_hit,
    output logic [ADDR_W-1:0]       head_cache_addr,
    input  logic                    head_cache_hit,
    output logic                    iss_valid,
    input  logic                    iss_ready,
    output logic [ADDR_W-1:0]       iss_addr,
    output logic [TIME_W-1:0]       iss_time,
    output logic                    bus_req,
    output logic [TIME_W-1:0]       bus_req_time,
    output logic [NUM_EV*CNT_W-1:0] stat_flat
);
    localparam int CNT_QW = $clog2(DEPTH + 1);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam logic [CNT_QW-1:0] FULL_CNT = CNT_QW'(DEPTH);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [TIME_W-1:0] time_q [DEPTH];
    logic [CNT_QW-1:0] cnt_q;
    logic [TIME_W-1:0] base_q;
    logic [TIME_W-1:0] breq_time_q;

    logic [ADDR_W-1:0] n_addr [DEPTH];
    logic [TIME_W-1:0] n_time [DEPTH];
    logic [CNT_QW-1:0] k_fill;
    logic [DEPTH-1:0]  live, keep0, rem, keep1, sq, keep2, miss_hit, cand_hit;
    logic              stop_sq, evict, push, pop, head_discard;
    logic              drop_cache, drop_mshr, drop_dup;
    logic              miss_acc;
    logic [ADDR_W-1:0] miss_blk, cand_blk;
    logic [TIME_W-1:0] cand_time;
    logic [NUM_EV-1:0] ev;

    pfq_miss_filter #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_filter (
        .miss_valid(miss_valid), .miss_uncacheable(miss_uncacheable),
        .miss_ifetch(miss_ifetch), .data_only(cfg_data_only),
        .miss_addr(miss_addr), .miss_acc(miss_acc), .miss_blk(miss_blk)
    );

    pfq_cam #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cam_miss (
        .ent_addr(addr_q), .live(live), .key(miss_blk), .hit(miss_hit)
    );

    pfq_cam #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_cam_cand (
        .ent_addr(addr_q), .live(live), .key(cand_blk), .hit(cand_hit)
    );

    // Candidate block address, ready time and lookup ports.
    assign cand_blk        = cand_addr & ~OFF_MASK;
    assign cand_time       = base_q + TIME_W'(cand_delay);
    assign cand_cache_addr = cand_blk;
    assign cand_mshr_addr  = cand_blk;
    assign head_cache_addr = addr_q[0];

    // Issue side: present the head unless a pop-time cache check rejects it.
    assign head_discard = (cnt_q != '0) && !cfg_check_on_push && head_cache_hit;
    assign iss_valid    = (cnt_q != '0) && !head_discard;
    assign iss_addr     = addr_q[0];
    assign iss_time     = time_q[0];
    assign pop          = head_discard || (iss_valid && iss_ready);
    assign bus_req      = (cnt_q != '0);
    assign bus_req_time = breq_time_q;

    // Slot occupancy from the entry count.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) live[i] = (CNT_QW'(i) < cnt_q);
    end

    // Survivor masks: pop first, then miss removal, then tail squash.
    always_comb begin
        keep0 = live;
        if (pop) keep0[0] = 1'b0;
        rem   = miss_acc ? (miss_hit & keep0) : '0;
        keep1 = keep0 & ~rem;
        sq      = '0;
        stop_sq = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (keep1[i] && !stop_sq) begin
                if (miss_acc && cfg_serial_squash && (time_q[i] >= miss_time)) sq[i] = 1'b1;
                else stop_sq = 1'b1;
            end
        end
        keep2 = keep1 & ~sq;
    end

    // Candidate filtering: cache (push mode), then MSHR, then queue duplicate.
    always_comb begin
        drop_cache = cand_valid && cfg_check_on_push && cand_cache_hit;
        drop_mshr  = cand_valid && !drop_cache && cand_mshr_hit;
        drop_dup   = cand_valid && !drop_cache && !drop_mshr && |(cand_hit & keep2);
        push       = cand_valid && !drop_cache && !drop_mshr && !drop_dup;
    end

    // Compact the survivors towards the head, then append the candidate.
    always_comb begin
        n_addr = addr_q;
        n_time = time_q;
        k_fill = '0;
        evict  = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep2[i]) begin
                n_addr[k_fill[IDX_W-1:0]] = addr_q[i];
                n_time[k_fill[IDX_W-1:0]] = time_q[i];
                k_fill = k_fill + 1'b1;
            end
        end
        if (push) begin
            if (k_fill == FULL_CNT) begin
                evict = 1'b1;
                for (int j = 0; j < DEPTH - 1; j++) begin
                    n_addr[j] = n_addr[j+1];
                    n_time[j] = n_time[j+1];
                end
                n_addr[DEPTH-1] = cand_blk;
                n_time[DEPTH-1] = cand_time;
            end else begin
                n_addr[k_fill[IDX_W-1:0]] = cand_blk;
                n_time[k_fill[IDX_W-1:0]] = cand_time;
                k_fill = k_fill + 1'b1;
            end
        end
    end

    // Queue state, miss base time and bus request tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            base_q      <= '0;
            breq_time_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                time_q[i] <= '0;
            end
        end else begin
            cnt_q  <= k_fill;
            addr_q <= n_addr;
            time_q <= n_time;
            if (miss_acc) base_q <= miss_time;
            if (push) breq_time_q <= cand_time;
        end
    end

    // Event pulses for the counters.
    always_comb begin
        ev            = '0;
        ev[EV_IDENT]  = cand_valid;
        ev[EV_MSHR]   = drop_mshr;
        ev[EV_CACHE]  = drop_cache || head_discard;
        ev[EV_QHIT]   = drop_dup;
        ev[EV_EVICT]  = evict;
        ev[EV_REMOVE] = |rem;
        ev[EV_SQUASH] = |sq;
        ev[EV_ISSUE]  = iss_valid && iss_ready;
    end

    pfq_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .ev(ev),
        .sq_n(CNT_W'($countones(sq))), .stat_flat(stat_flat)
    );

    // ---------------- assertions ----------------
    logic [IDX_W-1:0]  tail_idx;
    logic [TIME_W-1:0] tail_time;
    assign tail_idx  = IDX_W'(cnt_q - 1'b1);
    assign tail_time = time_q[tail_idx];

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    assert_full_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == FULL_CNT && !pop && !miss_acc && push) |=> (cnt_q == FULL_CNT));

    assert_req_on_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (bus_req && bus_req_time == $past(cand_time)));

    assert_squash_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_acc && cfg_serial_squash && !push) |=> (cnt_q == '0 || tail_time < $past(miss_time)));

    assert_remove_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_acc && miss_hit != '0 && !pop && !cfg_serial_squash && !push)
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    // Pairwise block uniqueness across live slots.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int j = i + 1; j < DEPTH; j++) begin
                    if (live[i] && live[j]) begin
                        assert_unique_R7: assert (addr_q[i] != addr_q[j])
                            else $error("duplicate block in queue");
                    end
                end
            end
        end
    end
endmodule

// File: tb/pf_cand_queue_tb.sv
// Directed bench for the prefetch candidate queue.
module pf_cand_queue_tb;
    localparam int AW = 32, TW = 16, DW = 8, CW = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_data_only, cfg_serial_squash, cfg_check_on_push;
    logic miss_valid, miss_uncacheable, miss_ifetch;
    logic [AW-1:0] miss_addr;
    logic [TW-1:0] miss_time;
    logic cand_valid;
    logic [AW-1:0] cand_addr;
    logic [DW-1:0] cand_delay;
    logic [AW-1:0] cand_cache_addr, cand_mshr_addr, head_cache_addr;
    logic cand_cache_hit, cand_mshr_hit, head_cache_hit;
    logic iss_valid, iss_ready, bus_req;
    logic [AW-1:0] iss_addr;
    logic [TW-1:0] iss_time, bus_req_time;
    logic [8*CW-1:0] stat_flat;

    logic [AW-1:0] cache_blk [2];
    logic [AW-1:0] mshr_blk [2];
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pf_cand_queue #(.ADDR_W(AW), .BLK_BYTES(64), .DEPTH(4), .TIME_W(TW),
                    .DELAY_W(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_data_only(cfg_data_only), .cfg_serial_squash(cfg_serial_squash),
        .cfg_check_on_push(cfg_check_on_push),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_time(miss_time),
        .miss_uncacheable(miss_uncacheable), .miss_ifetch(miss_ifetch),
        .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_delay(cand_delay),
        .cand_cache_addr(cand_cache_addr), .cand_cache_hit(cand_cache_hit),
        .cand_mshr_addr(cand_mshr_addr), .cand_mshr_hit(cand_mshr_hit),
        .head_cache_addr(head_cache_addr), .head_cache_hit(head_cache_hit),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr),
        .iss_time(iss_time), .bus_req(bus_req), .bus_req_time(bus_req_time),
        .stat_flat(stat_flat)
    );

    // Cache and MSHR models answering the combinational lookups.
    always_comb begin
        cand_cache_hit = (cand_cache_addr == cache_blk[0]) || (cand_cache_addr == cache_blk[1]);
        head_cache_hit = (head_cache_addr == cache_blk[0]) || (head_cache_addr == cache_blk[1]);
        cand_mshr_hit  = (cand_mshr_addr == mshr_blk[0]) || (cand_mshr_addr == mshr_blk[1]);
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_data_only = 1'b0; cfg_serial_squash = 1'b0; cfg_check_on_push = 1'b1;
        miss_valid = 1'b0; miss_uncacheable = 1'b0; miss_ifetch = 1'b0;
        miss_addr = '0; miss_time = '0;
        cand_valid = 1'b0; cand_addr = '0; cand_delay = '0; iss_ready = 1'b0;
        cache_blk[0] = '1; cache_blk[1] = '1; mshr_blk[0] = '1; mshr_blk[1] = '1;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic send_miss(input logic [AW-1:0] a, input logic [TW-1:0] t,
                             input logic unc, input logic ifc);
        miss_valid = 1'b1; miss_addr = a; miss_time = t;
        miss_uncacheable = unc; miss_ifetch = ifc;
        tick();
        miss_valid = 1'b0; miss_uncacheable = 1'b0; miss_ifetch = 1'b0;
    endtask

    task automatic send_cand(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cand_valid = 1'b1; cand_addr = a; cand_delay = d;
        tick();
        cand_valid = 1'b0;
    endtask

    task automatic take(input string tag, input logic [AW-1:0] ea, input logic [TW-1:0] et);
        chk({tag, " iss_valid"}, iss_valid, 1);
        chk({tag, " iss_addr"}, iss_addr, ea);
        chk({tag, " iss_time"}, iss_time, et);
        iss_ready = 1'b1;
        tick();
        iss_ready = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 bus_req", bus_req, 0);
        chk("R1 iss_valid", iss_valid, 0);
        chk("R1 counters", stat_flat, 0);
    endtask

    task automatic t_fifo();
        do_reset();
        send_miss(32'h1000, 16'd100, 0, 0);
        send_cand(32'h2047, 8'd3);
        send_cand(32'h3000, 8'd5);
        chk("R10 bus_req up", bus_req, 1);
        chk("R10 bus_req_time", bus_req_time, 16'd105);
        take("R3 R6 R12 first", 32'h2040, 16'd103);
        take("R12 second", 32'h3000, 16'd105);
        chk("R10 bus_req drop", bus_req, 0);
    endtask

    task automatic t_drops();
        do_reset();
        cache_blk[0] = 32'h5000; mshr_blk[0] = 32'h6000;
        send_miss(32'h4000, 16'd200, 0, 0);
        send_cand(32'h5010, 8'd1);
        chk("R8 cache drop", bus_req, 0);
        send_cand(32'h6020, 8'd1);
        chk("R7 mshr drop", bus_req, 0);
        send_cand(32'h7000, 8'd2);
        send_cand(32'h7030, 8'd4);
        chk("R7 dup keeps time", bus_req_time, 16'd202);
        take("R7 single entry", 32'h7000, 16'd202);
        chk("R7 dup not queued", bus_req, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        send_miss(32'h0, 16'd10, 0, 0);
        for (int i = 0; i < 5; i++) send_cand(32'h8000 + 32'(i) * 32'h40, 8'(i));
        for (int i = 1; i < 5; i++)
            take("R9 evict oldest", 32'h8000 + 32'(i) * 32'h40, 16'(10 + i));
        chk("R9 drained", bus_req, 0);
    endtask

    task automatic t_remove();
        do_reset();
        send_miss(32'hF000, 16'd300, 0, 0);
        send_cand(32'h9000, 8'd1);
        send_cand(32'h9040, 8'd2);
        send_cand(32'h9080, 8'd3);
        send_miss(32'h9050, 16'd301, 0, 0);
        take("R4 head kept", 32'h9000, 16'd301);
        take("R4 R5 no squash when off", 32'h9080, 16'd303);
        chk("R4 removed entry gone", bus_req, 0);
    endtask

    task automatic t_filter();
        do_reset();
        cfg_data_only = 1'b1;
        send_miss(32'hE000, 16'd50, 0, 0);
        send_cand(32'hE100, 8'd1);
        send_cand(32'hE140, 8'd2);
        send_miss(32'hE100, 16'd999, 1, 0);
        send_miss(32'hE140, 16'd999, 0, 1);
        send_cand(32'hE180, 8'd0);
        take("R2 uncacheable ignored", 32'hE100, 16'd51);
        take("R2 ifetch ignored", 32'hE140, 16'd52);
        take("R2 base time kept", 32'hE180, 16'd50);
        cfg_data_only = 1'b0;
        send_cand(32'hE1C0, 8'd0);
        send_miss(32'hE1C0, 16'd60, 0, 1);
        chk("R2 ifetch accepted", bus_req, 0);
    endtask

    task automatic t_squash();
        do_reset();
        cfg_serial_squash = 1'b1;
        send_miss(32'hA000, 16'd500, 0, 0);
        send_cand(32'h1100, 8'd1);
        send_cand(32'h1140, 8'd5);
        send_cand(32'h1180, 8'd9);
        send_miss(32'hA400, 16'd505, 0, 0);
        take("R5 older survives", 32'h1100, 16'd501);
        chk("R5 younger squashed", bus_req, 0);
        chk("R5 squash count", stat_flat[6*CW +: CW], 2);
    endtask

    task automatic t_popcheck();
        do_reset();
        cfg_check_on_push = 1'b0;
        cache_blk[0] = 32'hB000;
        send_miss(32'h0, 16'd600, 0, 0);
        send_cand(32'hB040, 8'd1);
        send_cand(32'hB000, 8'd2);
        chk("R11 pushed despite cache", bus_req_time, 16'd602);
        take("R11 clean head", 32'hB040, 16'd601);
        chk("R11 cached head hidden", iss_valid, 0);
        chk("R11 still requesting", bus_req, 1);
        tick();
        chk("R11 discarded", bus_req, 0);
        chk("R11 nothing issued", stat_flat[7*CW +: CW], 1);
    endtask

    task automatic t_counters();
        do_reset();
        cache_blk[0] = 32'h5000; mshr_blk[0] = 32'h6000;
        send_miss(32'hC000, 16'd10, 0, 0);
        send_cand(32'h5000, 8'd0);
        send_cand(32'h6000, 8'd0);
        send_cand(32'hC040, 8'd0);
        send_cand(32'hC040, 8'd0);
        send_cand(32'hC080, 8'd0);
        send_cand(32'hC0C0, 8'd0);
        send_cand(32'hC100, 8'd0);
        send_cand(32'hC140, 8'd0);
        cfg_serial_squash = 1'b1;
        send_miss(32'hC080, 16'd10, 0, 0);
        chk("R5 all squashed", bus_req, 0);
        send_cand(32'hD000, 8'd0);
        take("R13 final issue", 32'hD000, 16'd10);
        chk("R13 identified", stat_flat[0*CW +: CW], 9);
        chk("R13 mshr", stat_flat[1*CW +: CW], 1);
        chk("R13 cache", stat_flat[2*CW +: CW], 1);
        chk("R13 qhit", stat_flat[3*CW +: CW], 1);
        chk("R13 evict", stat_flat[4*CW +: CW], 1);
        chk("R13 remove", stat_flat[5*CW +: CW], 1);
        chk("R13 squash", stat_flat[6*CW +: CW], 3);
        chk("R13 issued", stat_flat[7*CW +: CW], 1);
    endtask

    initial begin
        t_reset();
        t_fifo();
        t_drops();
        t_overflow();
        t_remove();
        t_filter();
        t_squash();
        t_popcheck();
        t_counters();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule